// File: doc/BRIEF.md
# Register-Operand ALU with Flag-Only Sink Register

This block is a 16-bit execution unit that sits next to an eight-entry general register file and works only on register operands. It takes an operation code and register indices that have already been decoded and reads its operands from the register file. It returns a write-back value, a write-back enable and a target index, and it keeps a four-bit condition code register up to date.

Two operand forms are supported. In the three-operand form the unit computes `dst = src1 op src2` for add-with-carry, subtract, AND, OR and XOR. In the two-operand form, which only the two logical shifts use, the destination register supplies the value to shift and one source register supplies the shift count. The result is written back to the destination register.

Index zero works as a sink. When it is named as the destination, the write-back is suppressed but the condition codes still change. Compare and test operations can use it this way. Register contents come in through a separate load port, which stands in for the memory path that fills the register file. Loads may also target index zero, so register zero holds a real value that reads return.

Top module: `rgalu_core`

## Requirements
- R1: The register file holds eight 16-bit entries. A load (`ld_en` high) writes `ld_data` into entry `ld_idx` at the clock edge, and index 0 may be loaded. A read of any index, index 0 included, returns the stored value.
- R2: The three-operand codes are ADC=000, SUB=001, AND=010, OR=011 and XOR=100. For these codes `wb_data` is computed from reg[`rs1_idx`] and reg[`rs2_idx`]. When `op_valid` is high and `rd_idx` is nonzero, the result is written to reg[`rd_idx`] at the clock edge.
- R3: The two-operand codes are LSL=110 and LSR=111. The value shifted is reg[`rd_idx`] and the count is the full 16-bit unsigned value of reg[`rs1_idx`]; `rs2_idx` has no effect. A count of 0 returns the value unchanged, and a count of 16 or more returns 0.
- R4: When `rd_idx` is 0, `wb_en` stays low and no register changes, but the condition codes are updated exactly as they would be for any other destination.
- R5: ADC gives (src1 + src2 + C) mod 2^16. C becomes the carry out and V becomes the signed overflow of the addition.
- R6: SUB gives (src1 − src2) mod 2^16. C becomes the borrow (set when src1 < src2 as unsigned values) and V becomes the signed overflow of the subtraction.
- R7: `cc_q` is {N,Z,V,C} in bits 3..0. For every legal operation, N is bit 15 of the result and Z is set exactly when the result is zero. The new flags are visible after the clock edge that completes the operation.
- R8: AND, OR and XOR clear V and leave C unchanged.
- R9: Shifts clear V. For a count n from 1 to 16, C becomes the last bit shifted out: bit 16−n of the operand for LSL and bit n−1 for LSR. C becomes 0 for a count above 16 and is unchanged for a count of 0.
- R10: Code 101 is reserved. It produces no write-back and leaves the flags unchanged. The flags also hold while `op_valid` is low.
- R11: After reset, `cc_q` is 0 and every register reads 0.
- R12: If a write-back and a load target the same register in the same cycle, the write-back value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Decoded operation code |
| rd_idx | input | 3 | Destination index (also the shift operand) |
| rs1_idx | input | 3 | First source index (the shift count for shifts) |
| rs2_idx | input | 3 | Second source index |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 3 | Register load index |
| ld_data | input | 16 | Register load value |
| wb_en | output | 1 | Write-back enable |
| wb_idx | output | 3 | Write-back index |
| wb_data | output | 16 | Operation result |
| cc_q | output | 4 | Condition codes {N,Z,V,C} |

## Verification
The assertions check on every cycle that the sink register keeps its value when it is named as the destination. They also check that the flags hold on idle and reserved cycles, that N and Z agree with the result that was just produced, that logic operations clear V and keep C, and that every write-back or load commits to the addressed entry. The values of the sums, differences, borrows, overflows and shift carries can only be shown by the bench's scenarios. Those scenarios compare each result against an independent model, using directed boundary operands (counts of 0, 1, 15, 16, 17 and all ones, overflow and borrow edges) as well as random traffic.

// File: rtl/rgalu_pkg.sv
package rgalu_pkg;

   typedef enum logic [2:0] {
      OP_ADC = 3'b000,
      OP_SUB = 3'b001,
      OP_AND = 3'b010,
      OP_OR  = 3'b011,
      OP_XOR = 3'b100,
      OP_RSV = 3'b101,
      OP_LSL = 3'b110,
      OP_LSR = 3'b111
   } op_e;

   localparam int CC_W = 4;
   localparam int CC_N = 3;
   localparam int CC_Z = 2;
   localparam int CC_V = 1;
   localparam int CC_C = 0;

endpackage

// File: rtl/rgalu_regfile.sv
module rgalu_regfile #(
   parameter int DATA_W = 16,
   parameter int REG_N  = 8,
   parameter int IDX_W  = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wb_en,
   input  logic [IDX_W-1:0]               wb_idx,
   input  logic [DATA_W-1:0]              wb_data,
   input  logic                           ld_en,
   input  logic [IDX_W-1:0]               ld_idx,
   input  logic [DATA_W-1:0]              ld_data,
   output logic [REG_N-1:0][DATA_W-1:0]   rf_q
);

   logic [DATA_W-1:0] ent_q [REG_N];

   for (genvar e = 0; e < REG_N; e++) begin : g_ent
      logic hit_wb;
      logic hit_ld;
      assign hit_wb = wb_en && (wb_idx == IDX_W'(e));
      assign hit_ld = ld_en && (ld_idx == IDX_W'(e));

      // write-back outranks the load port on a shared index
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ent_q[e] <= '0;
         else if (hit_wb) ent_q[e] <= wb_data;
         else if (hit_ld) ent_q[e] <= ld_data;
      end

      assign rf_q[e] = ent_q[e];
   end

endmodule

// File: rtl/rgalu_arith.sv
module rgalu_arith
   import rgalu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              v_out,
   output logic              c_out
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] sum_x;
   logic [DATA_W:0] dif_x;

   assign sum_x = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, c_in};
   assign dif_x = {1'b0, a} - {1'b0, b};

   always_comb begin
      res   = '0;
      v_out = 1'b0;
      c_out = c_in;
      unique case (op)
         OP_ADC: begin
            res   = sum_x[DATA_W-1:0];
            c_out = sum_x[DATA_W];
            v_out = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
         end
         OP_SUB: begin
            res   = dif_x[DATA_W-1:0];
            c_out = dif_x[DATA_W];
            v_out = (a[MSB] != b[MSB]) && (dif_x[MSB] != a[MSB]);
         end
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: res = a ^ b;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/rgalu_shift.sv
module rgalu_shift #(
   parameter int DATA_W     = 16,
   parameter bit USE_BARREL = 1'b1
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] cnt,
   input  logic              go_left,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);

   localparam int EXT_W = DATA_W + 1;
   localparam int SH_W  = $clog2(EXT_W);

   function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] x);
      logic [DATA_W-1:0] y;
      for (int i = 0; i < DATA_W; i++) y[i] = x[DATA_W-1-i];
      return y;
   endfunction

   logic [EXT_W-1:0] ext_in;
   logic [EXT_W-1:0] ext_out;
   logic             cnt_over;
   logic             cnt_zero;

   // right shifts reuse the left shifter on a bit-reversed operand
   assign ext_in   = {1'b0, go_left ? opnd : flip(opnd)};
   assign cnt_over = cnt > DATA_W[DATA_W-1:0];
   assign cnt_zero = cnt == '0;

   if (USE_BARREL) begin : g_barrel
      logic [SH_W:0][EXT_W-1:0] stg;
      assign stg[0] = ext_in;
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         assign stg[k+1] = cnt[k] ? (stg[k] << (1 << k)) : stg[k];
      end
      assign ext_out = stg[SH_W];
   end else begin : g_flat
      assign ext_out = ext_in << cnt[SH_W-1:0];
   end

   always_comb begin
      if (cnt_zero) begin
         res   = opnd;
         c_out = c_in;
      end else if (cnt_over) begin
         res   = '0;
         c_out = 1'b0;
      end else begin
         res   = go_left ? ext_out[DATA_W-1:0] : flip(ext_out[DATA_W-1:0]);
         c_out = ext_out[DATA_W];
      end
   end

endmodule

// File: rtl/rgalu_core.sv
module rgalu_core
   import rgalu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int REG_N      = 8,
   parameter int IDX_W      = 3,
   parameter bit USE_BARREL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [IDX_W-1:0]  rs1_idx,
   input  logic [IDX_W-1:0]  rs2_idx,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic [CC_W-1:0]   cc_q
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("rgalu_core: DATA_W must be a power of two, at least 4");
   end
   if (REG_N < 2) begin : g_bad_depth
      $error("rgalu_core: REG_N must be at least 2");
   end
   if (IDX_W != $clog2(REG_N)) begin : g_bad_idx
      $error("rgalu_core: IDX_W must equal clog2(REG_N)");
   end

   op_e                          op;
   logic                         is_shift;
   logic                         is_logic;
   logic                         is_legal;
   logic                         act;
   logic [REG_N-1:0][DATA_W-1:0] rf_q;
   logic [DATA_W-1:0]            opnd_a;
   logic [DATA_W-1:0]            opnd_b;
   logic [DATA_W-1:0]            ar_res;
   logic                         ar_v;
   logic                         ar_c;
   logic [DATA_W-1:0]            sh_res;
   logic                         sh_c;
   logic [DATA_W-1:0]            result;
   logic [CC_W-1:0]              cc_next;

   assign op       = op_e'(op_code);
   assign is_shift = (op == OP_LSL) || (op == OP_LSR);
   assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   assign is_legal = op != OP_RSV;
   assign act      = op_valid && is_legal;

   // two-operand form: destination is the shifted value, first source the count
   assign opnd_a = rf_q[is_shift ? rd_idx  : rs1_idx];
   assign opnd_b = rf_q[is_shift ? rs1_idx : rs2_idx];

   rgalu_regfile #(
      .DATA_W (DATA_W),
      .REG_N  (REG_N),
      .IDX_W  (IDX_W)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wb_en   (wb_en),
      .wb_idx  (wb_idx),
      .wb_data (wb_data),
      .ld_en   (ld_en),
      .ld_idx  (ld_idx),
      .ld_data (ld_data),
      .rf_q    (rf_q)
   );

   rgalu_arith #(
      .DATA_W (DATA_W)
   ) u_arith (
      .op    (op),
      .a     (opnd_a),
      .b     (opnd_b),
      .c_in  (cc_q[CC_C]),
      .res   (ar_res),
      .v_out (ar_v),
      .c_out (ar_c)
   );

   rgalu_shift #(
      .DATA_W     (DATA_W),
      .USE_BARREL (USE_BARREL)
   ) u_shift (
      .opnd    (opnd_a),
      .cnt     (opnd_b),
      .go_left (op == OP_LSL),
      .c_in    (cc_q[CC_C]),
      .res     (sh_res),
      .c_out   (sh_c)
   );

   assign result = is_shift ? sh_res : ar_res;

   always_comb begin
      cc_next       = '0;
      cc_next[CC_N] = result[MSB];
      cc_next[CC_Z] = result == '0;
      cc_next[CC_V] = is_shift ? 1'b0 : ar_v;
      cc_next[CC_C] = is_shift ? sh_c : ar_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cc_q <= '0;
      else if (act) cc_q <= cc_next;
   end

   // index zero is a sink: flags move, storage does not
   assign wb_en   = act && (rd_idx != '0);
   assign wb_idx  = rd_idx;
   assign wb_data = is_legal ? result : '0;

   // R4
   r0_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && rd_idx == '0 && !(ld_en && ld_idx == '0)) |=> $stable(rf_q[0]));

   // R10
   cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_code != 3'b101) |=> $stable(cc_q));

   // R7
   z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> cc_q[CC_Z] == ($past(wb_data) == '0));

   // R7
   n_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> cc_q[CC_N] == $past(wb_data[MSB]));

   // R8
   logic_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_logic) |=> (!cc_q[CC_V] && cc_q[CC_C] == $past(cc_q[CC_C])));

   // R2
   wb_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> rf_q[$past(wb_idx)] == $past(wb_data));

   // R1
   ld_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !(wb_en && wb_idx == ld_idx)) |=> rf_q[$past(ld_idx)] == $past(ld_data));

endmodule

// File: tb/rgalu_core_tb.sv
`timescale 1ns/1ps
module rgalu_core_tb_top;

   typedef struct {
      bit          chk_data;
      bit          exp_en;
      logic [15:0] exp_data;
      logic [3:0]  exp_cc;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'b0;
   logic [2:0]  rd_idx = 3'b0;
   logic [2:0]  rs1_idx = 3'b0;
   logic [2:0]  rs2_idx = 3'b0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_idx = 3'b0;
   logic [15:0] ld_data = 16'h0;
   logic        wb_en;
   logic [2:0]  wb_idx;
   logic [15:0] wb_data;
   logic [3:0]  cc_q;

   int          n_chk = 0;
   int          n_fail = 0;
   bit          mon_on = 1'b0;
   bit          done = 1'b0;
   item_t       sb_q[$];
   logic [15:0] m_reg [8];
   logic [3:0]  m_cc;

   always #2 clk = ~clk;

   rgalu_core dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .cc_q(cc_q)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // independent reference: {N,Z,V,C}
   task automatic model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic [3:0] cc, output logic [15:0] r, output logic [3:0] cn);
      logic [16:0] w;
      logic        v;
      logic        c;
      int          n;
      v = 1'b0;
      c = cc[0];
      r = 16'h0;
      case (op)
         3'b000: begin
            w = 17'(a) + 17'(b) + 17'(cc[0]);
            r = w[15:0]; c = w[16];
            v = ($signed(a) + $signed(b) + int'(cc[0]) > 32767) ||
                ($signed(a) + $signed(b) + int'(cc[0]) < -32768);
         end
         3'b001: begin
            r = a - b; c = a < b;
            v = (int'($signed(a)) - int'($signed(b)) > 32767) ||
                (int'($signed(a)) - int'($signed(b)) < -32768);
         end
         3'b010: r = a & b;
         3'b011: r = a | b;
         3'b100: r = a ^ b;
         3'b110, 3'b111: begin
            n = int'(b);
            if (n == 0) r = a;
            else if (n > 16) begin r = 16'h0; c = 1'b0; end
            else if (op == 3'b110) begin r = (n == 16) ? 16'h0 : a << n; c = a[16-n]; end
            else begin r = (n == 16) ? 16'h0 : a >> n; c = a[n-1]; end
         end
         default: r = 16'h0;
      endcase
      cn = {r[15], r == 16'h0, v, c};
   endtask

   function automatic string tag_for(input logic [2:0] op, input logic [2:0] rd);
      string t;
      case (op)
         3'b000: t = "R2/R5/R7";
         3'b001: t = "R2/R6/R7";
         3'b110, 3'b111: t = "R3/R9/R7";
         3'b101: t = "R10";
         default: t = "R2/R8/R7";
      endcase
      if (rd == 3'b0) t = {t, "/R4"};
      return t;
   endfunction

   task automatic drive(input logic [2:0] op, input logic [2:0] rd, input logic [2:0] s1,
                        input logic [2:0] s2, input bit ld, input logic [2:0] li,
                        input logic [15:0] ldv, input string tag_in);
      item_t       it;
      logic [15:0] a, b, r;
      logic [3:0]  cn;
      bit          legal;
      @(posedge clk); #1;
      op_valid = 1'b1; op_code = op; rd_idx = rd; rs1_idx = s1; rs2_idx = s2;
      ld_en = ld; ld_idx = li; ld_data = ldv;
      legal = (op != 3'b101);
      a = op[2:1] == 2'b11 ? m_reg[rd] : m_reg[s1];
      b = op[2:1] == 2'b11 ? m_reg[s1] : m_reg[s2];
      model(op, a, b, m_cc, r, cn);
      it.chk_data = legal;
      it.exp_en   = legal && (rd != 3'b0);
      it.exp_data = r;
      it.exp_cc   = legal ? cn : m_cc;
      it.tag      = (tag_in.len() > 0) ? tag_in : tag_for(op, rd);
      sb_q.push_back(it);
      if (ld) m_reg[li] = ldv;
      if (it.exp_en) m_reg[rd] = r;
      m_cc = it.exp_cc;
   endtask

   task automatic op_t(input logic [2:0] op, input logic [2:0] rd, input logic [2:0] s1, input logic [2:0] s2);
      drive(op, rd, s1, s2, 1'b0, 3'b0, 16'h0, "");
   endtask

   task automatic idle_t(input bit ld, input logic [2:0] li, input logic [15:0] ldv, input string tag);
      item_t it;
      @(posedge clk); #1;
      op_valid = 1'b0; ld_en = ld; ld_idx = li; ld_data = ldv;
      op_code = 3'($urandom); rd_idx = 3'($urandom);
      it.chk_data = 1'b0; it.exp_en = 1'b0; it.exp_data = 16'h0;
      it.exp_cc = m_cc; it.tag = tag;
      sb_q.push_back(it);
      if (ld) m_reg[li] = ldv;
   endtask

   // reads a register back through a flag-only OR into index zero
   task automatic peek(input logic [2:0] r, input string tag);
      drive(3'b011, 3'b0, r, r, 1'b0, 3'b0, 16'h0, tag);
   endtask

   // monitor: result checked in its own cycle, flags one edge later
   initial begin
      item_t it;
      bit    pend = 1'b0;
      item_t pv;
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (pend) check(cc_q == pv.exp_cc, {pv.tag, " cc"}, 16'(cc_q), 16'(pv.exp_cc));
            pend = 1'b0;
            if (sb_q.size() > 0) begin
               it = sb_q.pop_front();
               check(wb_en == it.exp_en, {it.tag, " wb_en"}, 16'(wb_en), 16'(it.exp_en));
               if (it.chk_data) check(wb_data == it.exp_data, {it.tag, " wb_data"}, wb_data, it.exp_data);
               if (it.exp_en) check(wb_idx == rd_idx, {it.tag, " wb_idx"}, 16'(wb_idx), 16'(rd_idx));
               pv = it; pend = 1'b1;
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] vals [6];
      for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
      m_cc = 4'h0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(cc_q == 4'h0, "R11 cc after reset", 16'(cc_q), 16'h0);
      check(wb_en == 1'b0, "R11 wb_en idle", 16'(wb_en), 16'h0);
      mon_on = 1'b1;
      for (int r = 0; r < 8; r++) peek(3'(r), "R11 reg reset");

      // R1 loads, index zero included, then readback
      for (int r = 0; r < 8; r++) idle_t(1'b1, 3'(r), 16'(16'h1111 * (r + 1)), "R1 load");
      for (int r = 0; r < 8; r++) peek(3'(r), "R1 readback");

      // R5 carry chain and overflow edges
      idle_t(1'b1, 3'd1, 16'hFFFF, "R1 load"); idle_t(1'b1, 3'd2, 16'h0001, "R1 load");
      op_t(3'b000, 3'd3, 3'd1, 3'd2);          // 0, C=1, Z=1
      op_t(3'b000, 3'd3, 3'd2, 3'd2);          // 1+1+C
      idle_t(1'b1, 3'd1, 16'h7FFF, "R1 load");
      op_t(3'b000, 3'd4, 3'd1, 3'd2);          // signed overflow
      // R6 borrow and equality
      op_t(3'b001, 3'd5, 3'd2, 3'd2);
      op_t(3'b001, 3'd5, 3'd2, 3'd1);
      idle_t(1'b1, 3'd6, 16'h8000, "R1 load");
      op_t(3'b001, 3'd5, 3'd6, 3'd2);          // 0x8000-1 overflows
      // R4 compare into the sink: flags change, R0 stays
      op_t(3'b001, 3'd0, 3'd1, 3'd6);
      peek(3'd0, "R4 sink unchanged");
      // R8 logic keeps C
      op_t(3'b001, 3'd7, 3'd2, 3'd1);          // sets C
      op_t(3'b010, 3'd7, 3'd1, 3'd6);
      op_t(3'b100, 3'd7, 3'd1, 3'd1);
      op_t(3'b011, 3'd0, 3'd1, 3'd6);

      // R3/R9 shift counts 0,1,15,16,17,all ones, both directions
      vals = '{16'd0, 16'd1, 16'd15, 16'd16, 16'd17, 16'hFFFF};
      foreach (vals[k]) begin
         idle_t(1'b1, 3'd2, vals[k], "R1 load");
         idle_t(1'b1, 3'd3, 16'hA5C3, "R1 load");
         op_t(3'b110, 3'd3, 3'd2, 3'($urandom));
         idle_t(1'b1, 3'd3, 16'h5A3C, "R1 load");
         op_t(3'b111, 3'd3, 3'd2, 3'($urandom));
      end
      // R3 rs2 has no effect on a shift
      idle_t(1'b1, 3'd2, 16'd3, "R1 load");
      drive(3'b111, 3'd0, 3'd2, 3'd5, 1'b0, 3'b0, 16'h0, "R3 rs2 ignored a");
      drive(3'b111, 3'd0, 3'd2, 3'd6, 1'b0, 3'b0, 16'h0, "R3 rs2 ignored b");

      // R10 reserved code and idle cycles leave flags and registers
      op_t(3'b001, 3'd0, 3'd2, 3'd1);
      op_t(3'b101, 3'd4, 3'd1, 3'd2);
      idle_t(1'b0, 3'd0, 16'h0, "R10 idle");
      peek(3'd4, "R10 reserved no write");

      // R12 write-back beats a load to the same register
      drive(3'b011, 3'd5, 3'd1, 3'd2, 1'b1, 3'd5, 16'hDEAD, "R12 collide");
      peek(3'd5, "R12 winner");
      drive(3'b011, 3'd0, 3'd1, 3'd2, 1'b1, 3'd0, 16'hBEEF, "R12/R4 sink load");
      peek(3'd0, "R1 R0 load kept");

      // random traffic
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 3) == 0)
            idle_t(1'b1, 3'($urandom), ($urandom_range(0, 2) == 0) ? 16'($urandom_range(0, 20)) : 16'($urandom), "R1 load");
         else begin
            logic [2:0] op;
            op = 3'($urandom);
            op_t(op, 3'($urandom), 3'($urandom), 3'($urandom));
         end
      end
      for (int r = 0; r < 8; r++) peek(3'(r), "R2 final readback");
      idle_t(1'b0, 3'd0, 16'h0, "R10 idle");
      idle_t(1'b0, 3'd0, 16'h0, "R10 idle");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule